// File: doc/BRIEF.md
# Three-Stage Fetch Program Counter

This block is the instruction-fetch front end of a small 32-bit processor whose pipeline has three stages: fetch, decode and execute. It owns the program counter and the instruction-state flag, which selects either full-width 32-bit instructions or a compact 16-bit encoding. Each cycle it offers the counter as a fetch request to the one memory port that carries both instructions and data. An accepted word moves into the decode slot and then into the execute slot. Only one word can be in each slot at a time, so when the port is busy fetching stops and a bubble goes into decode.

The executing instruction sees its own address, its raw word, its instruction state and the program-counter value that a read of the PC returns. Because of the pipeline, that value is ahead of the instruction's own address. A redirect from a branch or an exception vector loads a new counter and state, and it empties both younger slots. A stall freezes the whole front end.

The fetch request is a valid/ready stream. `fetch_valid` is high whenever the front end is neither stalled nor redirecting. The request is taken only in a cycle where `fetch_ready` is also high, and `fetch_rdata` must hold the word at `fetch_addr` in that same cycle. When `fetch_ready` is low, the counter holds and the same address is offered again in the next cycle. The other pins are plain level controls.

Top module: `fetch_front`

## Requirements
- R1: After reset, `fetch_addr` equals RESET_ADDR (default 0), the state is 32-bit (`exec_compact` = 0), both pipeline slots are empty, `exec_valid` is 0 and `fetch_valid` is 1.
- R2: Each accepted fetch (`fetch_valid` and `fetch_ready` high, no redirect) advances `fetch_addr` by 4 in 32-bit state and by 2 in compact state (flag value 1).
- R3: An accepted word appears at the execute outputs two non-stalled cycles after it is accepted, with its address and word, and words leave in the order they were fetched.
- R4: While `exec_valid` is high, `exec_pc_read` equals `exec_addr` + 8 in 32-bit state and `exec_addr` + 4 in compact state.
- R5: In 32-bit state, bits 1 and 0 of a redirect target are ignored and loaded as zero.
- R6: In compact state, bit 0 of a redirect target is ignored and loaded as zero, while bit 1 is kept.
- R7: A redirect loads the counter and empties both slots at the next edge. It wins over a stall. The target is then in execute two cycles after the redirect edge, provided there is no stall and the port is ready.
- R8: While `stall` is high and there is no redirect, `fetch_valid` is 0, and the counter and both slots keep their values.
- R9: When the port is not ready and there is neither a stall nor a redirect, the counter holds, a bubble enters decode, and the word that was in decode moves on to execute.
- R10: The state given with a redirect sets the increment and the PC-read offset, starting with the target instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze the counter and both slots |
| redirect_valid | input | 1 | Load a branch or exception target this cycle |
| redirect_addr | input | 32 | Redirect target byte address |
| redirect_compact | input | 1 | State for the target: 1 = compact 16-bit, 0 = 32-bit |
| fetch_valid | output | 1 | A fetch request is offered |
| fetch_ready | input | 1 | The shared memory port takes the request |
| fetch_addr | output | 32 | Byte address of the fetch (the program counter) |
| fetch_rdata | input | 32 | Word returned for `fetch_addr` in the accepting cycle |
| exec_valid | output | 1 | The execute slot holds an instruction |
| exec_addr | output | 32 | Address of the executing instruction |
| exec_instr | output | 32 | Word of the executing instruction |
| exec_compact | output | 1 | State of the executing instruction |
| exec_pc_read | output | 32 | Value a PC read returns for the executing instruction |

## Verification
The hardest situation to reach is a state change that happens while the pipeline is being refilled. A redirect arrives together with a stall and switches state, and the new step and offset must then apply from the target instruction onward. The stimulus table sends a redirect to an odd address in compact state during a stall. It then follows the refill cycle by cycle and watches the increment go from 4 to 2 and the PC-read offset go from 8 to 4. The table also places a port-busy cycle straight after a stall, which puts a bubble between two valid instructions in execute.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  parameter int unsigned XLEN = 32;

  typedef enum logic {
    ST_WIDE    = 1'b0,
    ST_COMPACT = 1'b1
  } isa_state_e;

  typedef struct packed {
    logic             valid;
    isa_state_e       st;
    logic [XLEN-1:0]  addr;
    logic [XLEN-1:0]  instr;
  } slot_t;

  function automatic logic [XLEN-1:0] step_bytes(isa_state_e st);
    return (st == ST_COMPACT) ? XLEN'(2) : XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] view_offset(isa_state_e st);
    return (st == ST_COMPACT) ? XLEN'(4) : XLEN'(8);
  endfunction

  function automatic logic [XLEN-1:0] align_addr(logic [XLEN-1:0] a, isa_state_e st);
    logic [XLEN-1:0] r;
    r = a;
    r[0] = 1'b0;
    if (st == ST_WIDE) r[1] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/fetch_pc.sv
module fetch_pc
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            redir_valid,
  input  logic [XLEN-1:0] redir_addr,
  input  isa_state_e      redir_st,
  output logic [XLEN-1:0] pc,
  output isa_state_e      st
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_ADDR;
      st <= ST_WIDE;
    end else if (redir_valid) begin
      pc <= align_addr(redir_addr, redir_st);
      st <= redir_st;
    end else if (advance) begin
      pc <= pc + step_bytes(st);
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !redir_valid) |=> (pc - $past(pc)) == (($past(st) == ST_COMPACT) ? XLEN'(2) : XLEN'(4)));

  // R5
  pc_wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_st == ST_WIDE) |=> pc[1:0] == 2'b00);

  // R6
  pc_compact_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_st == ST_COMPACT) |=> (pc[0] == 1'b0 && pc[1] == $past(redir_addr[1])));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !redir_valid) |=> ($stable(pc) && $stable(st)));
endmodule

// File: rtl/pipe_slot.sv
module pipe_slot
  import fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  flush,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (flush) begin
      q.valid <= 1'b0;
    end else if (load) begin
      q <= d;
    end
  end

  // R7
  slot_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q.valid);

  // R8
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !flush) |=> $stable(q));
endmodule

// File: rtl/pc_view.sv
module pc_view
  import fetch_pkg::*;
(
  input  logic [XLEN-1:0] addr,
  input  isa_state_e      st,
  output logic [XLEN-1:0] pc_read
);
  always_comb pc_read = addr + view_offset(st);
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0,
  parameter int unsigned STAGES     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        redirect_valid,
  input  logic [31:0] redirect_addr,
  input  logic        redirect_compact,
  output logic        fetch_valid,
  input  logic        fetch_ready,
  output logic [31:0] fetch_addr,
  input  logic [31:0] fetch_rdata,
  output logic        exec_valid,
  output logic [31:0] exec_addr,
  output logic [31:0] exec_instr,
  output logic        exec_compact,
  output logic [31:0] exec_pc_read
);
  localparam int unsigned LAST = STAGES - 1;

  logic [XLEN-1:0] pc;
  isa_state_e      cur_st;
  isa_state_e      redir_st;
  logic            fetch_fire;
  logic            shift;
  slot_t           chain [STAGES+1];

  assign redir_st    = redirect_compact ? ST_COMPACT : ST_WIDE;
  assign fetch_valid = !stall && !redirect_valid;
  assign fetch_fire  = fetch_valid && fetch_ready;
  assign shift       = !stall;
  assign fetch_addr  = pc;

  fetch_pc #(.RESET_ADDR(RESET_ADDR)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (fetch_fire),
    .redir_valid (redirect_valid),
    .redir_addr  (redirect_addr),
    .redir_st    (redir_st),
    .pc          (pc),
    .st          (cur_st)
  );

  always_comb begin
    chain[0].valid = fetch_fire;
    chain[0].st    = cur_st;
    chain[0].addr  = pc;
    chain[0].instr = fetch_rdata;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_slot
    pipe_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (shift),
      .flush (redirect_valid),
      .d     (chain[g]),
      .q     (chain[g+1])
    );
  end

  assign exec_valid   = chain[LAST+1].valid;
  assign exec_addr    = chain[LAST+1].addr;
  assign exec_instr   = chain[LAST+1].instr;
  assign exec_compact = (chain[LAST+1].st == ST_COMPACT);

  pc_view u_view (
    .addr    (chain[LAST+1].addr),
    .st      (chain[LAST+1].st),
    .pc_read (exec_pc_read)
  );

  // R9
  busy_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect_valid && !fetch_ready) |=> (!chain[1].valid && $stable(fetch_addr)));

  // R8
  stall_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !fetch_valid);

  // R5
  exec_wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_compact) |-> exec_addr[1:0] == 2'b00);

  // R3
  exec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect_valid && chain[1].valid) |=> (exec_valid && exec_addr == $past(chain[1].addr)));
endmodule

// File: tb/fetch_front_test.sv
module fetch_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic        redirect_compact = 1'b0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b1;
  logic [31:0] fetch_addr;
  logic [31:0] fetch_rdata;
  logic        exec_valid;
  logic [31:0] exec_addr;
  logic [31:0] exec_instr;
  logic        exec_compact;
  logic [31:0] exec_pc_read;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [31:0] MARK = 32'hA5A5_0000;

  always #10 clk = ~clk;

  assign fetch_rdata = fetch_addr ^ MARK;

  fetch_front uut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .redirect_compact(redirect_compact),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
    .exec_valid(exec_valid), .exec_addr(exec_addr), .exec_instr(exec_instr),
    .exec_compact(exec_compact), .exec_pc_read(exec_pc_read)
  );

  typedef struct packed {
    logic        stall;
    logic        ready;
    logic        rv;
    logic [31:0] raddr;
    logic        rc;
    logic [31:0] exp_pc;
    logic        exp_ev;
    logic [31:0] exp_ea;
    logic        exp_cmp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h004, 1'b0, 32'h000, 1'b0}, // R2
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h008, 1'b1, 32'h000, 1'b0}, // R3
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h00C, 1'b1, 32'h004, 1'b0}, // R3
    '{1'b1,1'b1,1'b0,32'h0,  1'b0, 32'h00C, 1'b1, 32'h004, 1'b0}, // R8
    '{1'b0,1'b0,1'b0,32'h0,  1'b0, 32'h00C, 1'b1, 32'h008, 1'b0}, // R9
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h010, 1'b0, 32'h000, 1'b0}, // R9
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h014, 1'b1, 32'h00C, 1'b0}, // R3
    '{1'b0,1'b1,1'b1,32'h103,1'b0, 32'h100, 1'b0, 32'h000, 1'b0}, // R5
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h104, 1'b0, 32'h000, 1'b0}, // R7
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h108, 1'b1, 32'h100, 1'b0}, // R7
    '{1'b1,1'b1,1'b1,32'h207,1'b1, 32'h206, 1'b0, 32'h000, 1'b0}, // R6
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h208, 1'b0, 32'h000, 1'b0}, // R10
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h20A, 1'b1, 32'h206, 1'b1}, // R10
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h20C, 1'b1, 32'h208, 1'b1}, // R4
    '{1'b0,1'b1,1'b1,32'h302,1'b0, 32'h300, 1'b0, 32'h000, 1'b0}, // R5
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h304, 1'b0, 32'h000, 1'b0}, // R10
    '{1'b0,1'b1,1'b0,32'h0,  1'b0, 32'h308, 1'b1, 32'h300, 1'b0}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    @(posedge clk);
    @(negedge clk);
    check("R1 fetch_addr", fetch_addr, 32'h0);
    check("R1 exec_valid", {31'b0, exec_valid}, 32'h0);
    check("R1 fetch_valid", {31'b0, fetch_valid}, 32'h1);
    check("R1 exec_compact", {31'b0, exec_compact}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      stall            = VECS[i].stall;
      fetch_ready      = VECS[i].ready;
      redirect_valid   = VECS[i].rv;
      redirect_addr    = VECS[i].raddr;
      redirect_compact = VECS[i].rc;
      #1;
      // R8: no request while stalled or redirecting
      check("R8 fetch_valid", {31'b0, fetch_valid}, {31'b0, !(VECS[i].stall || VECS[i].rv)});
      @(negedge clk);
      check("R2 fetch_addr", fetch_addr, VECS[i].exp_pc);
      check("R3 exec_valid", {31'b0, exec_valid}, {31'b0, VECS[i].exp_ev});
      if (VECS[i].exp_ev) begin
        check("R3 exec_addr", exec_addr, VECS[i].exp_ea);
        check("R3 exec_instr", exec_instr, VECS[i].exp_ea ^ MARK);
        check("R10 exec_compact", {31'b0, exec_compact}, {31'b0, VECS[i].exp_cmp});
        check("R4 exec_pc_read", exec_pc_read,
              VECS[i].exp_ea + (VECS[i].exp_cmp ? 32'd4 : 32'd8));
      end
    end

    // R8: a long stall keeps the counter and execute slot
    stall = 1'b1; redirect_valid = 1'b0; fetch_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 held fetch_addr", fetch_addr, 32'h308);
    check("R8 held exec_addr", exec_addr, 32'h300);
    stall = 1'b0;

    // R6: compact target with bit 1 set and bit 0 set keeps bit 1
    redirect_valid = 1'b1; redirect_addr = 32'h403; redirect_compact = 1'b1;
    @(negedge clk);
    redirect_valid = 1'b0;
    check("R6 target", fetch_addr, 32'h402);
    check("R7 flushed", {31'b0, exec_valid}, 32'h0);
    repeat (2) @(negedge clk);
    check("R7 target in exec", exec_addr, 32'h402);
    check("R4 compact read", exec_pc_read, 32'h406);

    // R1: reset mid-run returns to 32-bit state at RESET_ADDR
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset addr", fetch_addr, 32'h0);
    check("R1 re-reset exec", {31'b0, exec_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 step after reset", fetch_addr, 32'h8);
    check("R1 wide after reset", {31'b0, exec_compact}, 32'h0);

    finish_run();
  end
endmodule